// File: doc/BRIEF.md
# MDIO Command Engine

This block runs one clause-22 MDIO management frame toward an external PHY each time a host writes its single 32-bit command word. The word holds a busy flag, the opcode, a 5-bit PHY address, a 5-bit register address and 16 data bits. A write that is accepted sets busy. The engine then divides the system clock down to MDC and shifts out the frame: preamble, start, opcode, the two addresses and the turnaround. It then either drives 16 data bits or releases the line and samples 16 bits from the PHY. When the frame ends, busy clears. For a read, the low half of the word then holds the data that came back.

Software polls the busy flag. If no PHY answers a read, the pulled-up line returns all ones. A scan helper reuses the same engine. It reads register 1 of PHY addresses 0 upward and records the address of each PHY that answers. It stops after a parameterised number of hits or after address 31.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command word reads 0, MDC is low, the MDIO output enable is low, no scan is running and the hit count is 0.
- R2: A host write while idle stores bits 30:0 as written and sets bit 31 (busy). The stored word is visible on the next clock.
- R3: The frame is 64 bits, MSB first: 32 ones, start 01, opcode from bits 29:28, PHY address from bits 27:23 and register address from bits 22:18. On a write (opcode 01) it continues with turnaround 10 and data bits 15:0.
- R4: MDC has a period of MDC_DIV clocks and is low while idle. MDIO changes only on the falling edge of MDC and is sampled on the rising edge.
- R5: On a read (opcode 10) the engine releases MDIO from the first turnaround bit to the end of the frame. It captures 16 data bits into bits 15:0, and bits 30:16 keep the command.
- R6: A read from an address with no PHY returns 0xFFFF in bits 15:0.
- R7: Busy clears exactly 64*MDC_DIV clocks after the clock edge that accepted the write. Read data is valid in that same cycle.
- R8: A host write that arrives while busy is set leaves the word unchanged and starts no frame.
- R9: A scan start pulse reads register 1 at PHY address 0, 1, 2 and so on, one full frame per address. A PHY counts as present when it returns anything but 0xFFFF. Hit addresses are listed in ascending order, the first in bits 4:0 of the list. The scan stops after SCAN_MAX hits or after address 31.
- R10: Host writes are ignored while a scan is running, so the scan issues no write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for the command word |
| host_wdata | input | 32 | Command word to write |
| host_rdata | output | 32 | Current command word, busy in bit 31 |
| scan_go | input | 1 | Pulse that starts a PHY scan |
| scan_busy | output | 1 | Scan in progress |
| scan_hits | output | $clog2(SCAN_MAX+1) | Number of PHYs found |
| scan_list | output | SCAN_MAX*5 | Found PHY addresses, 5 bits each, first in the low bits |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
Busy rises on the clock after the accepted write. The bench reads the word at the next falling clock edge for R2. It then counts exactly 64*MDC_DIV-1 more falling clock edges and expects busy still set, and one edge later expects it clear with the read data already in place. Other results are only sampled once busy or scan_busy reads 0. A bench PHY model captures the frame on MDC rising edges and answers reads on MDC falling edges. Frame contents, the turnaround release and the number of frames per scan are therefore all judged after the frame has ended.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int CMD_W    = 32;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int BUSY_BIT = 31;
  localparam int OP_LSB   = 28;
  localparam int PHY_LSB  = 23;
  localparam int REG_LSB  = 18;
  localparam int PRE_LEN  = 32;
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int TA_IDX   = PRE_LEN + 14;
  localparam int DATA_IDX = PRE_LEN + 16;
  localparam int LAST_PHY = (1 << ADDR_W) - 1;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [ADDR_W-1:0] SCAN_REG = 5'd1;

  typedef enum logic [1:0] {SC_IDLE, SC_ISSUE, SC_WAIT} scan_state_t;

  // Full serial frame, element FRAME_LEN-1 goes out first.
  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic [1:0]        op,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rg,
    input logic [DATA_W-1:0] wd
  );
    return {{PRE_LEN{1'b1}}, 2'b01, op, phy, rg, 2'b10, wd};
  endfunction

  function automatic logic [CMD_W-1:0] read_word(
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rg
  );
    logic [CMD_W-1:0] w;
    w = '0;
    w[30] = 1'b1;
    w[OP_LSB +: 2] = OP_READ;
    w[PHY_LSB +: ADDR_W] = phy;
    w[REG_LSB +: ADDR_W] = rg;
    w[17] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV = 16,
  localparam int CNT_W = $clog2(DIV),
  localparam int HALF  = DIV / 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;

  assign rise_o = en_i && (cnt_q == CNT_W'(HALF - 1));
  assign fall_o = en_i && (cnt_q == CNT_W'(DIV - 1));
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + 1'b1;
      if (rise_o)      mdc_q <= 1'b1;
      else if (fall_o) mdc_q <= 1'b0;
    end
  end

  // R4
  mdc_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_o |-> !mdc_q) and (fall_o |-> mdc_q));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_mgmt_pkg::*;
#(
  localparam int IDX_W = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              active_o,
  output logic              done_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic                 active_q;
  logic                 rd_q;
  logic [IDX_W-1:0]     idx_q;
  logic [FRAME_LEN-1:0] sh_q;
  logic                 mdio_q;
  logic                 oe_q;
  logic [DATA_W-1:0]    rdata_q;
  logic                 last_bit;
  logic [IDX_W-1:0]     idx_nxt;

  assign last_bit  = (idx_q == IDX_W'(FRAME_LEN - 1));
  assign idx_nxt   = idx_q + 1'b1;
  assign done_o    = active_q && fall_i && last_bit;
  assign active_o  = active_q;
  assign mdio_o    = mdio_q;
  assign mdio_oe_o = oe_q;
  assign rdata_o   = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '1;
      mdio_q   <= 1'b1;
      oe_q     <= 1'b0;
      rdata_q  <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      rd_q     <= (op_i == OP_READ);
      idx_q    <= '0;
      sh_q     <= build_frame(op_i, phy_i, reg_i, wdata_i);
      mdio_q   <= 1'b1;
      oe_q     <= 1'b1;
    end else if (active_q) begin
      if (rise_i && rd_q && (idx_q >= IDX_W'(DATA_IDX)))
        rdata_q <= {rdata_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last_bit) begin
          active_q <= 1'b0;
          oe_q     <= 1'b0;
          mdio_q   <= 1'b1;
        end else begin
          idx_q  <= idx_nxt;
          sh_q   <= {sh_q[FRAME_LEN-2:0], 1'b1};
          mdio_q <= sh_q[FRAME_LEN-2];
          if (rd_q && (idx_nxt >= IDX_W'(TA_IDX))) oe_q <= 1'b0;
        end
      end
    end
  end

  // R4
  mdio_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_q) |-> $past(fall_i || start_i));

  // R5
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && rd_q && (idx_q >= IDX_W'(TA_IDX))) |-> !oe_q);
endmodule

// File: rtl/mdio_scan.sv
module mdio_scan
  import mdio_mgmt_pkg::*;
#(
  parameter int SCAN_MAX = 4,
  localparam int HIT_W = $clog2(SCAN_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       go_i,
  input  logic                       busy_i,
  input  logic                       done_i,
  input  logic [DATA_W-1:0]          rdata_i,
  output logic                       active_o,
  output logic                       wr_o,
  output logic [CMD_W-1:0]           word_o,
  output logic [HIT_W-1:0]           hits_o,
  output logic [SCAN_MAX*ADDR_W-1:0] list_o
);
  scan_state_t       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [HIT_W-1:0]  hits_q;
  logic              accept;
  logic              hit_now;
  logic              stop_now;

  assign accept   = go_i && (state_q == SC_IDLE) && !busy_i;
  assign hit_now  = (state_q == SC_WAIT) && done_i && (rdata_i != '1);
  assign stop_now = (hit_now && (hits_q == HIT_W'(SCAN_MAX - 1))) ||
                    (addr_q == ADDR_W'(LAST_PHY));
  assign wr_o     = (state_q == SC_ISSUE) && !busy_i;
  assign word_o   = read_word(addr_q, SCAN_REG);
  assign active_o = (state_q != SC_IDLE);
  assign hits_o   = hits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SC_IDLE;
      addr_q  <= '0;
      hits_q  <= '0;
    end else begin
      case (state_q)
        SC_IDLE: if (accept) begin
          state_q <= SC_ISSUE;
          addr_q  <= '0;
          hits_q  <= '0;
        end
        SC_ISSUE: if (wr_o) state_q <= SC_WAIT;
        SC_WAIT: if (done_i) begin
          if (hit_now) hits_q <= hits_q + 1'b1;
          if (stop_now) state_q <= SC_IDLE;
          else begin
            addr_q  <= addr_q + 1'b1;
            state_q <= SC_ISSUE;
          end
        end
        default: state_q <= SC_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < SCAN_MAX; g++) begin : g_slot
    logic [ADDR_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst || accept) slot_q <= '0;
      else if (hit_now && (hits_q == HIT_W'(g))) slot_q <= addr_q;
    end
    assign list_o[g*ADDR_W +: ADDR_W] = slot_q;
  end

  // R9
  scan_limit_chk: assert property (@(posedge clk) disable iff (rst)
    hits_q <= HIT_W'(SCAN_MAX));

  // R9
  scan_order_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != SC_IDLE && !accept) |=> addr_q >= $past(addr_q));
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_DIV     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SCAN_MAX    = 4,
  localparam int HIT_W = $clog2(SCAN_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       host_wr,
  input  logic [31:0]                host_wdata,
  output logic [31:0]                host_rdata,
  input  logic                       scan_go,
  output logic                       scan_busy,
  output logic [HIT_W-1:0]           scan_hits,
  output logic [SCAN_MAX*ADDR_W-1:0] scan_list,
  output logic                       mdc,
  output logic                       mdio_o,
  output logic                       mdio_oe,
  input  logic                       mdio_i
);
  logic [CMD_W-1:0]  cmd_q;
  logic [CMD_W-1:0]  ld_word;
  logic [CMD_W-1:0]  scan_word;
  logic              busy;
  logic              host_take;
  logic              scan_wr;
  logic              load;
  logic              eng_active;
  logic              eng_done;
  logic [DATA_W-1:0] eng_rdata;
  logic              rise_stb;
  logic              fall_stb;
  logic              mdio_sync;

  assign busy       = cmd_q[BUSY_BIT];
  assign host_take  = host_wr && !busy && !scan_busy;
  assign load       = host_take || scan_wr;
  assign ld_word    = scan_wr ? scan_word : host_wdata;
  assign host_rdata = cmd_q;

  // Input synchronizer for the pad
  if (SYNC_STAGES < 2) begin : g_sync1
    logic s_q;
    always_ff @(posedge clk) s_q <= rst ? 1'b1 : mdio_i;
    assign mdio_sync = s_q;
  end else begin : g_syncn
    logic [SYNC_STAGES-1:0] s_q;
    always_ff @(posedge clk) begin
      if (rst) s_q <= '1;
      else     s_q <= {s_q[SYNC_STAGES-2:0], mdio_i};
    end
    assign mdio_sync = s_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (load) begin
      cmd_q <= {1'b1, ld_word[CMD_W-2:0]};
    end else if (eng_done) begin
      cmd_q[BUSY_BIT] <= 1'b0;
      if (cmd_q[OP_LSB +: 2] == OP_READ) cmd_q[DATA_W-1:0] <= eng_rdata;
    end
  end

  mdio_clkdiv #(.DIV(MDC_DIV)) u_div (
    .clk    (clk),
    .rst    (rst),
    .en_i   (eng_active),
    .mdc_o  (mdc),
    .rise_o (rise_stb),
    .fall_o (fall_stb)
  );

  mdio_frame u_frame (
    .clk       (clk),
    .rst       (rst),
    .start_i   (load),
    .op_i      (ld_word[OP_LSB +: 2]),
    .phy_i     (ld_word[PHY_LSB +: ADDR_W]),
    .reg_i     (ld_word[REG_LSB +: ADDR_W]),
    .wdata_i   (ld_word[DATA_W-1:0]),
    .rise_i    (rise_stb),
    .fall_i    (fall_stb),
    .mdio_i    (mdio_sync),
    .active_o  (eng_active),
    .done_o    (eng_done),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe),
    .rdata_o   (eng_rdata)
  );

  mdio_scan #(.SCAN_MAX(SCAN_MAX)) u_scan (
    .clk      (clk),
    .rst      (rst),
    .go_i     (scan_go),
    .busy_i   (busy),
    .done_i   (eng_done),
    .rdata_i  (eng_rdata),
    .active_o (scan_busy),
    .wr_o     (scan_wr),
    .word_o   (scan_word),
    .hits_o   (scan_hits),
    .list_o   (scan_list)
  );

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && busy && !eng_done) |=> $stable(cmd_q));

  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    eng_done |-> (busy && eng_active));
endmodule

// File: tb/test_mdio_cmd_engine.sv
module test_mdio_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;
  localparam int SMAX       = 4;
  localparam int HW         = $clog2(SMAX + 1);
  localparam int FRAME_CYC  = 64 * DIV;
  localparam int WD_LIMIT   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic scan_go = 1'b0;
  logic scan_busy;
  logic [HW-1:0] scan_hits;
  logic [SMAX*5-1:0] scan_list;
  logic mdc, mdio_o, mdio_oe, mdio_i;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int frame_tag = 0;
  int seen_tag = 0;
  int rise_tag = -1;
  int last_rise = 0;
  int per_cnt = 0;
  int per_bad = 0;
  int n = 0;
  int oe_err = 0;
  int wr_frames = 0;
  logic busy_d = 1'b0;
  logic mdc_d = 1'b0;
  logic [63:0] cap = '0;
  logic [31:0] present = '0;
  logic phy_oe = 1'b0;
  logic phy_bit = 1'b1;

  assign mdio_i = phy_oe ? phy_bit : (mdio_oe ? mdio_o : 1'b1);

  mdio_cmd_engine #(.MDC_DIV(DIV), .SCAN_MAX(SMAX)) i_mdio_cmd_engine (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .scan_go(scan_go), .scan_busy(scan_busy),
    .scan_hits(scan_hits), .scan_list(scan_list), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] phy_val(input logic [4:0] ph, input logic [4:0] rg);
    return {rg, ph, 6'b011001} ^ 16'h5A5A;
  endfunction

  function automatic logic [31:0] rd_cmd(input logic [4:0] ph, input logic [4:0] rg);
    return 32'h6002_0000 | (32'(ph) << 23) | (32'(rg) << 18);
  endfunction

  function automatic logic [31:0] wr_cmd(input logic [4:0] ph, input logic [4:0] rg,
                                         input logic [15:0] d);
    return 32'h5002_0000 | (32'(ph) << 23) | (32'(rg) << 18) | 32'(d);
  endfunction

  function automatic logic [63:0] exp_frame(input logic [31:0] w);
    return {32'hFFFF_FFFF, 2'b01, w[29:28], w[27:23], w[22:18], 2'b10, w[15:0]};
  endfunction

  function automatic logic [15:0] exp_read(input logic [4:0] ph, input logic [4:0] rg);
    return present[ph] ? phy_val(ph, rg) : 16'hFFFF;
  endfunction

  // Clock-domain observer: frame starts and MDC period
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (host_rdata[31] && !busy_d) frame_tag = frame_tag + 1;
    if (mdc && !mdc_d) begin
      if (rise_tag == frame_tag) begin
        per_cnt = per_cnt + 1;
        if (cyc - last_rise != DIV) per_bad = per_bad + 1;
      end
      rise_tag = frame_tag;
      last_rise = cyc;
    end
    busy_d = host_rdata[31];
    mdc_d = mdc;
    if (cyc > WD_LIMIT) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WD_LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // PHY model, capture side
  always @(posedge mdc) begin
    if (frame_tag != seen_tag) begin
      seen_tag = frame_tag;
      n = 0;
      cap = '0;
    end
    if (n < 64) begin
      if (mdio_oe) cap[63-n] = mdio_o;
      if (n >= 46 && {cap[29], cap[28]} == 2'b10 && mdio_oe) oe_err = oe_err + 1;
      n = n + 1;
      if (n == 64 && {cap[29], cap[28]} == 2'b01) wr_frames = wr_frames + 1;
    end
  end

  // PHY model, answer side
  always @(negedge mdc) begin
    if (n >= 47 && n < 64 && {cap[29], cap[28]} == 2'b10 && present[cap[27:23]]) begin
      phy_oe = 1'b1;
      if (n == 47) phy_bit = 1'b0;
      else begin
        logic [15:0] v;
        v = phy_val(cap[27:23], cap[22:18]);
        phy_bit = v[63-n];
      end
    end else begin
      phy_oe = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (host_rdata[31]) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [31:0] w, input string req);
    logic [31:0] exp;
    issue(w);
    wait_idle();
    @(negedge clk);
    exp = {1'b0, w[30:16], (w[29:28] == 2'b10) ? exp_read(w[27:23], w[22:18]) : w[15:0]};
    check(host_rdata == exp, req, "readback", 64'(host_rdata), 64'(exp));
    if (w[29:28] == 2'b10)
      check(cap[63:18] == exp_frame(w)[63:18], "R3", "read header", cap, exp_frame(w));
    else
      check(cap == exp_frame(w), "R3", "write frame", cap, exp_frame(w));
  endtask

  initial begin
    logic [31:0] w;
    logic [31:0] wb;
    int t0;
    int wf0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(host_rdata == 32'h0, "R1", "word", 64'(host_rdata), 64'h0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "mdc/oe", {mdc, mdio_oe}, 64'h0);
    check(scan_busy == 1'b0 && scan_hits == '0, "R1", "scan", {scan_busy, scan_hits}, 64'h0);

    present = (32'd1 << 4) | (32'd1 << 7) | (32'd1 << 20);

    // R2, R7: directed write with exact busy timing
    w = wr_cmd(5'd4, 5'd9, 16'hBEEF);
    issue(w);
    check(host_rdata == {1'b1, w[30:0]}, "R2", "stored word", 64'(host_rdata), 64'({1'b1, w[30:0]}));
    repeat (FRAME_CYC - 1) @(negedge clk);
    check(host_rdata[31] == 1'b1, "R7", "busy before end", 64'(host_rdata[31]), 64'h1);
    @(negedge clk);
    check(host_rdata[31] == 1'b0, "R7", "busy at end", 64'(host_rdata[31]), 64'h0);
    check(host_rdata == {1'b0, w[30:0]}, "R2", "word after write", 64'(host_rdata), 64'({1'b0, w[30:0]}));
    check(cap == exp_frame(w), "R3", "write frame", cap, exp_frame(w));
    check(per_cnt > 0 && per_bad == 0, "R4", "mdc period", 64'(per_bad), 64'h0);
    check(mdc == 1'b0, "R4", "mdc idle low", 64'(mdc), 64'h0);

    // R5, R7: read from a present PHY, data valid when busy clears
    w = rd_cmd(5'd7, 5'd2);
    issue(w);
    repeat (FRAME_CYC) @(negedge clk);
    check(host_rdata == {1'b0, w[30:16], phy_val(5'd7, 5'd2)}, "R5", "read data",
          64'(host_rdata), 64'({1'b0, w[30:16], phy_val(5'd7, 5'd2)}));

    // R6: absent PHY
    run_cmd(rd_cmd(5'd0, 5'd1), "R6");
    check(host_rdata[15:0] == 16'hFFFF, "R6", "absent data", 64'(host_rdata[15:0]), 64'hFFFF);

    // R8: write while busy is ignored
    w = wr_cmd(5'd20, 5'd3, 16'h1357);
    wb = wr_cmd(5'd9, 5'd30, 16'h2468);
    issue(w);
    repeat (100) @(negedge clk);
    host_wr = 1'b1;
    host_wdata = wb;
    @(negedge clk);
    host_wr = 1'b0;
    check(host_rdata == {1'b1, w[30:0]}, "R8", "word unchanged", 64'(host_rdata), 64'({1'b1, w[30:0]}));
    wait_idle();
    @(negedge clk);
    check(cap == exp_frame(w), "R8", "frame of first cmd", cap, exp_frame(w));
    check(host_rdata == {1'b0, w[30:0]}, "R8", "final word", 64'(host_rdata), 64'({1'b0, w[30:0]}));

    // Random mix, R3 R5 R6
    present = $urandom;
    for (int i = 0; i < 16; i++) begin
      logic [4:0] ph;
      logic [4:0] rg;
      logic [15:0] d;
      ph = 5'($urandom % 32);
      rg = 5'($urandom % 32);
      d  = 16'($urandom);
      if ($urandom % 2 == 0) run_cmd(rd_cmd(ph, rg), "R5");
      else                   run_cmd(wr_cmd(ph, rg, d), "R3");
    end
    check(oe_err == 0, "R5", "mdio released on read", 64'(oe_err), 64'h0);

    // R9: scan stops after SMAX hits, R10 host write ignored
    present = (32'd1 << 3) | (32'd1 << 7) | (32'd1 << 8) | (32'd1 << 20) | (32'd1 << 30);
    t0 = frame_tag;
    wf0 = wr_frames;
    @(negedge clk);
    scan_go = 1'b1;
    @(negedge clk);
    scan_go = 1'b0;
    check(scan_busy == 1'b1, "R9", "scan started", 64'(scan_busy), 64'h1);
    repeat (700) @(negedge clk);
    host_wr = 1'b1;
    host_wdata = wb;
    @(negedge clk);
    host_wr = 1'b0;
    while (scan_busy) @(negedge clk);
    wait_idle();
    @(negedge clk);
    check(scan_hits == 3'(SMAX), "R9", "hits", 64'(scan_hits), 64'(SMAX));
    check(scan_list == {5'd20, 5'd8, 5'd7, 5'd3}, "R9", "list", 64'(scan_list),
          64'({5'd20, 5'd8, 5'd7, 5'd3}));
    check(frame_tag - t0 == 21, "R9", "frames in scan", 64'(frame_tag - t0), 64'd21);
    check(host_rdata[27:23] == 5'd20 && host_rdata[22:18] == 5'd1, "R9", "last probe",
          64'(host_rdata[27:18]), 64'({5'd20, 5'd1}));
    check(host_rdata[15:0] == phy_val(5'd20, 5'd1), "R9", "last data",
          64'(host_rdata[15:0]), 64'(phy_val(5'd20, 5'd1)));
    check(wr_frames == wf0, "R10", "no write frame during scan", 64'(wr_frames), 64'(wf0));

    // R9: scan that runs through address 31
    present = (32'd1 << 5) | (32'd1 << 31);
    t0 = frame_tag;
    @(negedge clk);
    scan_go = 1'b1;
    @(negedge clk);
    scan_go = 1'b0;
    while (scan_busy) @(negedge clk);
    wait_idle();
    @(negedge clk);
    check(scan_hits == 3'd2, "R9", "hits full sweep", 64'(scan_hits), 64'd2);
    check(scan_list == {5'd0, 5'd0, 5'd31, 5'd5}, "R9", "list full sweep", 64'(scan_list),
          64'({5'd0, 5'd0, 5'd31, 5'd5}));
    check(frame_tag - t0 == 32, "R9", "frames full sweep", 64'(frame_tag - t0), 64'd32);
    check(host_rdata[27:23] == 5'd31, "R9", "last address", 64'(host_rdata[27:23]), 64'd31);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule